// File: doc/BRIEF.md
# Table-Driven SPI Serial Clock Divider

This block derives a serial clock for an SPI controller from the faster module clock. A small rate index picks the divide ratio from a fixed table. Each step up the table multiplies the ratio alternately by 4/3 and by 3/2, so the ratios are powers of two and three times powers of two. The block also gives two single-cycle strobes that a downstream shift register can use: one when the serial clock leaves its idle level and one when it returns to it. Clock phase handling is left to that shift register, which chooses which strobe shifts and which samples.

The table has two guarded entries. Index 0 never makes a clock. Index 1 (divide by three) makes a clock only while a fast-mode input is high. Indices above a parameterised maximum are clamped to that maximum. A new index is taken up only at an idle point: while the block is disabled, while the selected entry gives no clock, or at the end of a complete serial clock period. A package function also returns the index a software setup step would choose for a wanted serial rate.

Top module: `spi_clk_div`

## Requirements
- R1: For a legal index k, the serial clock period is N module clock cycles. For even k, N = 2^(k/2+1). For odd k, N = 3·2^((k-1)/2). This gives 4 for k=2, 24 for k=7, 48 for k=9 and 1024 for k=18.
- R2: Index 0 keeps `sclk` at the idle level, and neither strobe pulses while enable is high.
- R3: Index 1 gives N = 3 while `fast_mode` is 1. With `fast_mode` at 0 it behaves like index 0.
- R4: An index above MAX_IDX (default 18) is treated as MAX_IDX. With the default, indices 19 and 31 both give N = 1024.
- R5: Within each period, `sclk` first sits at the idle level for ceil(N/2) cycles and then at the active level for floor(N/2) cycles. Even ratios are exactly 50 % duty.
- R6: The idle level of `sclk` equals `cpol`, and the active level is its inverse. While `en` is 0, the counter is held, and from the next cycle `sclk` is at idle with no strobes. After `en` rises, the first leading strobe appears on the ceil(N/2)-th rising clock edge that samples `en` high.
- R7: `lead_stb` is high for exactly one cycle, the first cycle at the active level. `trail_stb` is high for exactly one cycle, the first cycle back at the idle level. The two are never high together.
- R8: A change of `rate_idx` while a period is running does not alter that period. The new ratio starts with the idle half that follows the trailing edge.
- R9: The package function `spi_div_pick_idx(fin, fspi, max_idx)` returns the smallest k with 2 ≤ k < max_idx and N(k)·fspi ≥ fin. If no such k exists it returns max_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the divider; low holds it at idle |
| cpol | input | 1 | Idle level of the serial clock |
| fast_mode | input | 1 | Allows the divide-by-3 entry (index 1) |
| rate_idx | input | IDX_W (5) | Rate table index |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse on entering the active level |
| trail_stb | output | 1 | One-cycle pulse on returning to the idle level |

## Verification
Suppose the held ratio or the half-period counter is wrong. The error shows on the first leading strobe after enable, or at the latest one full period later. The leading strobe, the trailing strobe and the next leading strobe land at ceil(N/2), N and N+ceil(N/2) cycles, so a wrong half length or a swapped duty split moves at least one of them by a cycle or more. A ratio taken up mid-period shows within the same period, because the trailing strobe moves to the new half length. A guard on index 0 or index 1 that leaks makes a strobe appear inside a short idle window.

// File: rtl/spi_div_pkg.sv
`timescale 1ns/1ps
package spi_div_pkg;

    parameter int IDX_W  = 5;
    parameter int HALF_W = 10;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_ACT  = 1'b1
    } phase_e;

    typedef struct packed {
        logic              valid;
        logic [HALF_W-1:0] act_len;
        logic [HALF_W-1:0] idle_len;
    } half_cfg_t;

    // Divide ratio of table entry k (0 for the reserved entry).
    function automatic logic [31:0] spi_div_ratio(input logic [IDX_W-1:0] k);
        logic [31:0] r;
        if (k == '0)
            r = '0;
        else if (!k[0])
            r = 32'd1 << ((k >> 1) + 1);
        else
            r = 32'd3 << ((k - IDX_W'(1)) >> 1);
        return r;
    endfunction

    // Resolve an index into half-period lengths, with clamping and guards.
    function automatic half_cfg_t spi_div_make_cfg(input logic [IDX_W-1:0] idx,
                                                   input logic fast,
                                                   input logic [IDX_W-1:0] max_k);
        half_cfg_t   c;
        logic [IDX_W-1:0] k;
        logic [31:0] n;
        logic [31:0] n_up;
        k       = (idx > max_k) ? max_k : idx;
        n       = spi_div_ratio(k);
        n_up    = n + 32'd1;
        c.valid = (k != '0) && !((k == IDX_W'(1)) && !fast);
        c.act_len  = n[HALF_W:1];
        c.idle_len = n_up[HALF_W:1];
        return c;
    endfunction

    // Index a setup step would choose for a target serial rate.
    function automatic int unsigned spi_div_pick_idx(input longint unsigned fin,
                                                     input longint unsigned fspi,
                                                     input int unsigned max_idx);
        for (int i = 2; i < 32; i++) begin
            if (i < int'(max_idx)) begin
                if (longint'(spi_div_ratio(IDX_W'(i))) * fspi >= fin)
                    return i;
            end
        end
        return max_idx;
    endfunction

endpackage

// File: rtl/spi_div_rate_sel.sv
`timescale 1ns/1ps
module spi_div_rate_sel
    import spi_div_pkg::*;
#(
    parameter int MAX_IDX = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             fast_mode,
    input  logic [IDX_W-1:0] rate_idx,
    output half_cfg_t        cfg_q
);
    localparam logic [IDX_W-1:0] MAX_K = IDX_W'(MAX_IDX);

    half_cfg_t cfg_next;

    always_comb begin
        cfg_next = spi_div_make_cfg(rate_idx, fast_mode, MAX_K);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_next;
    end

    // R8: the held ratio moves only after an idle point
    a_r8_change_at_idle: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> $past(load));

    // R2: the reserved entry never yields a runnable ratio
    a_r2_reserved_blocked: assert property (@(posedge clk) disable iff (rst)
        (load && rate_idx == '0) |=> !cfg_q.valid);

    // R3: divide-by-3 needs the fast mode flag
    a_r3_div3_gated: assert property (@(posedge clk) disable iff (rst)
        (load && rate_idx == IDX_W'(1) && !fast_mode) |=> !cfg_q.valid);

endmodule

// File: rtl/spi_div_phase.sv
`timescale 1ns/1ps
module spi_div_phase
    import spi_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  half_cfg_t cfg,
    output phase_e    phase_q,
    output logic      lead_q,
    output logic      trail_q,
    output logic      period_end
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half_len;
    logic              half_done;
    logic              run;

    always_comb begin
        run        = en && cfg.valid;
        half_len   = (phase_q == PH_ACT) ? cfg.act_len : cfg.idle_len;
        half_done  = (cnt_q == half_len - HALF_W'(1));
        period_end = run && (phase_q == PH_ACT) && half_done;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            if (half_done) begin
                cnt_q <= '0;
                if (phase_q == PH_IDLE) begin
                    phase_q <= PH_ACT;
                    lead_q  <= 1'b1;
                end else begin
                    phase_q <= PH_IDLE;
                    trail_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + HALF_W'(1);
            end
        end
    end

    // R7: strobes never coincide
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(lead_q && trail_q));

    // R7: a leading strobe marks the first cycle of the active level
    a_r7_lead_entry: assert property (@(posedge clk) disable iff (rst)
        lead_q |-> (phase_q == PH_ACT) && ($past(phase_q) == PH_IDLE));

    // R5: the counter stays inside the current half
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < half_len));

    // R6: disable returns to idle without strobes
    a_r6_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase_q == PH_IDLE) && !lead_q && !trail_q);

    // R2: no ratio, no strobes
    a_r2_quiet_invalid: assert property (@(posedge clk) disable iff (rst)
        !cfg.valid |=> !lead_q && !trail_q);

endmodule

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div
    import spi_div_pkg::*;
#(
    parameter int MAX_IDX = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cpol,
    input  logic             fast_mode,
    input  logic [IDX_W-1:0] rate_idx,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    half_cfg_t cfg;
    phase_e    phase;
    logic      period_end;
    logic      load;

    assign load = !en || !cfg.valid || period_end;

    spi_div_rate_sel #(.MAX_IDX(MAX_IDX)) u_rate_sel (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .fast_mode (fast_mode),
        .rate_idx  (rate_idx),
        .cfg_q     (cfg)
    );

    spi_div_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cfg        (cfg),
        .phase_q    (phase),
        .lead_q     (lead_stb),
        .trail_q    (trail_stb),
        .period_end (period_end)
    );

    assign sclk = cpol ^ (phase == PH_ACT);

    // R6: idle level follows cpol during reset
    a_r6_reset_idle: assert property (@(posedge clk)
        rst |=> (sclk == cpol) && !lead_stb && !trail_stb);

endmodule

// File: tb/test_spi_clk_div.sv
`timescale 1ns/1ps
module test_spi_clk_div;
    import spi_div_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             cpol = 1'b0;
    logic             fast_mode = 1'b0;
    logic [IDX_W-1:0] rate_idx = '0;
    logic             sclk;
    logic             lead_stb;
    logic             trail_stb;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_clk_div i_spi_clk_div (
        .clk(clk), .rst(rst), .en(en), .cpol(cpol), .fast_mode(fast_mode),
        .rate_idx(rate_idx), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_ratio(input logic [IDX_W-1:0] idx, input bit fast, input bit pol,
                             input int exp_n, input string tag);
        int lo = (exp_n + 1) / 2;
        int hi = exp_n / 2;
        int lead1 = -1, trail1 = -1, lead2 = -1;
        int act = 0, wide = 0, both = 0;
        int limit = (exp_n == 0) ? 64 : 2 * exp_n + 8;
        bit prev_lead = 1'b0;
        @(negedge clk);
        en = 1'b0; rate_idx = idx; fast_mode = fast; cpol = pol;
        repeat (3) @(negedge clk);
        check(sclk == pol, "R6 idle level", sclk, pol);
        en = 1'b1;
        for (int t = 1; t <= limit; t++) begin
            @(negedge clk);
            if (lead_stb && trail_stb) both++;
            if (lead_stb && prev_lead) wide++;
            prev_lead = lead_stb;
            if (lead_stb && lead1 < 0) lead1 = t;
            else if (lead_stb && lead2 < 0 && trail1 >= 0) lead2 = t;
            if (trail_stb && trail1 < 0 && lead1 >= 0) trail1 = t;
            if (lead1 >= 0 && trail1 < 0 && sclk != pol) act++;
        end
        en = 1'b0;
        if (exp_n == 0) begin
            check(lead1 == -1, {tag, " no leading strobe"}, lead1, -1);
            check(trail1 == -1, {tag, " no trailing strobe"}, trail1, -1);
            check(sclk == pol, {tag, " sclk idle"}, sclk, pol);
        end else begin
            check(lead1 == lo, "R6 first leading edge", lead1, lo);
            check(trail1 == exp_n, {tag, " period"}, trail1, exp_n);
            check(lead2 == exp_n + lo, {tag, " next leading edge"}, lead2, exp_n + lo);
            check(act == hi, "R5 active cycles", act, hi);
            check(wide == 0 && both == 0, "R7 strobe width", wide + both, 0);
        end
    endtask

    task automatic t_reset;
        check(sclk == cpol && !lead_stb && !trail_stb, "R6 reset state",
              {sclk, lead_stb, trail_stb}, {cpol, 2'b00});
    endtask

    task automatic t_rate_change;
        int t = 0, trail1 = -1, lead2 = -1;
        bit changed = 1'b0;
        @(negedge clk);
        en = 1'b0; rate_idx = 5'd2; fast_mode = 1'b0; cpol = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        while (t < 40 && lead2 < 0) begin
            @(negedge clk);
            t++;
            if (changed && trail_stb && trail1 < 0) trail1 = t;
            if (changed && trail1 >= 0 && lead_stb) lead2 = t;
            if (lead_stb && !changed) begin
                changed = 1'b1;
                rate_idx = 5'd4;
                t = 0;
            end
        end
        en = 1'b0;
        // old ratio 4: trail 2 cycles after lead; new ratio 8: idle half of 4
        check(trail1 == 2, "R8 running period kept", trail1, 2);
        check(lead2 == 6, "R8 new ratio after trailing edge", lead2, 6);
    endtask

    task automatic t_disable_mid;
        int strobes = 0;
        @(negedge clk);
        en = 1'b0; rate_idx = 5'd4; fast_mode = 1'b0; cpol = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (lead_stb) break;
        end
        check(sclk == 1'b0, "R6 active level is inverse of cpol", sclk, 0);
        en = 1'b0;
        @(negedge clk);
        check(sclk == 1'b1, "R6 idle after disable", sclk, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (lead_stb || trail_stb) strobes++;
        end
        check(strobes == 0, "R6 no strobes while disabled", strobes, 0);
    endtask

    task automatic t_pick;
        check(spi_div_pick_idx(100, 10, 18) == 5, "R9 pick 100/10",
              int'(spi_div_pick_idx(100, 10, 18)), 5);
        check(spi_div_pick_idx(100, 100, 18) == 2, "R9 pick starts at 2",
              int'(spi_div_pick_idx(100, 100, 18)), 2);
        check(spi_div_pick_idx(48, 1, 18) == 9, "R9 pick exact 48",
              int'(spi_div_pick_idx(48, 1, 18)), 9);
        check(spi_div_pick_idx(1000000, 1, 16) == 16, "R9 fallback 16",
              int'(spi_div_pick_idx(1000000, 1, 16)), 16);
        check(spi_div_pick_idx(1000000, 1, 18) == 18, "R9 fallback 18",
              int'(spi_div_pick_idx(1000000, 1, 18)), 18);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        run_ratio(5'd2,  1'b0, 1'b0, 4,    "R1");
        run_ratio(5'd7,  1'b0, 1'b1, 24,   "R1");
        run_ratio(5'd18, 1'b0, 1'b0, 1024, "R1");
        run_ratio(5'd9,  1'b0, 1'b0, 48,   "R5");
        run_ratio(5'd1,  1'b1, 1'b0, 3,    "R3");
        run_ratio(5'd1,  1'b1, 1'b1, 3,    "R5");
        run_ratio(5'd1,  1'b0, 1'b0, 0,    "R3");
        run_ratio(5'd0,  1'b1, 1'b0, 0,    "R2");
        run_ratio(5'd0,  1'b0, 1'b1, 0,    "R2");
        run_ratio(5'd31, 1'b0, 1'b0, 1024, "R4");
        run_ratio(5'd19, 1'b0, 1'b1, 1024, "R4");
        t_rate_change();
        t_disable_mid();
        t_pick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule